// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a virtual address onto a physical address through one of three segments (code, heap and stack). The two most significant virtual address bits pick the segment and the rest form the offset. Each segment has its own physical base, a size limit and a control nibble. The control nibble holds the read, write and execute permissions and a flag that makes the segment grow downward. An access that is outside the segment, that the permissions do not allow, or that targets an unused segment returns a fault code and a physical address of zero.

A request is sampled on a clock edge. The translated address and fault code appear on registered outputs one cycle later. All segment state is held in a small register set. Software writes and reads it through a simple port, for example to save and restore it across a context switch.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every segment has base 0, limit 0 and control 0. Every register reads back 0, and any access returns fault code 11.
- R2: Virtual address bits [VA_W-1:VA_W-2] select the segment: 00 is code (slot 0), 01 is heap (slot 1) and 11 is stack (slot 3). The low OFS_W bits are the offset.
- R3: Select value 10 always returns fault code 11 (unused segment).
- R4: A segment whose limit is 0 is unused. Any access to it returns fault code 11.
- R5: In an upward segment (control bit 3 clear), an access with offset < limit translates to base + offset, modulo 2^PA_W. Otherwise it returns fault code 01 (out of bounds).
- R6: In a downward segment (control bit 3 set), the magnitude is 2^OFS_W - offset. An access with magnitude <= limit translates to base - magnitude, modulo 2^PA_W. Otherwise it returns fault code 01.
- R7: Access code 00 (read) needs control bit 0, 01 (write) needs bit 1 and 10 (execute) needs bit 2. Code 11 is reserved and is never allowed. An access that is not allowed returns fault code 10. When several faults apply, the code order is 11, then 01, then 10.
- R8: Whenever the fault code is not 00, pa_o is 0.
- R9: The result of a request sampled on a clock edge is on resp_valid_o, pa_o and fault_o after that edge. A cycle with no request gives resp_valid_o=0, pa_o=0 and fault_o=00.
- R10: A register write addresses a slot (wsel_i) and a field (wfield_i): 00 is base (low PA_W bits of the data), 01 is limit (low OFS_W+1 bits) and 10 is control (low 4 bits). rdata_o combinationally returns the addressed field, zero-extended. Writes to slot 10 or to field 11 are ignored, and reads of either return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| va_i | input | VA_W | Virtual address |
| acc_i | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| resp_valid_o | output | 1 | Result valid |
| pa_o | output | PA_W | Physical address, 0 on fault |
| fault_o | output | 2 | 00 none, 01 bounds, 10 protection, 11 unused segment |
| we_i | input | 1 | Register write strobe |
| wsel_i | input | 2 | Slot written |
| wfield_i | input | 2 | Field written |
| wdata_i | input | DATA_W | Write data |
| rsel_i | input | 2 | Slot read |
| rfield_i | input | 2 | Field read |
| rdata_o | output | DATA_W | Read data |

## Verification
The hardest cases to reach are the edges of the downward limit check. An offset of zero gives the full segment size as its magnitude, and a magnitude exactly equal to the limit must still translate. Purely random addresses almost never land on these points. Directed cases therefore program a stack segment and probe offsets just on each side of the limit and at zero. The random phase then reprograms segments with random limits (sometimes 0, sometimes the maximum) and draws most offsets within a few steps of the limit, so both sides of the comparison are exercised in both directions.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_PROT   = 2'b10,
    FLT_UNUSED = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'b00,
    FLD_LIMIT = 2'b01,
    FLD_CTRL  = 2'b10,
    FLD_RSV   = 2'b11
  } field_e;

  typedef struct packed {
    logic down;
    logic x;
    logic w;
    logic r;
  } seg_ctrl_t;

  localparam int unsigned NUM_SLOTS   = 4;
  localparam int unsigned UNUSED_SLOT = 2;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W   = 24,
  parameter int unsigned BND_W  = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        wsel_i,
  input  logic [1:0]        wfield_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        rsel_i,
  input  logic [1:0]        rfield_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PA_W-1:0]   base_o  [NUM_SLOTS],
  output logic [BND_W-1:0]  limit_o [NUM_SLOTS],
  output seg_ctrl_t         ctrl_o  [NUM_SLOTS]
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == UNUSED_SLOT) begin : g_hole
      assign base_o[g]  = '0;
      assign limit_o[g] = '0;
      assign ctrl_o[g]  = '0;
    end else begin : g_regs
      logic hit;
      assign hit = we_i && (wsel_i == 2'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_o[g]  <= '0;
          limit_o[g] <= '0;
          ctrl_o[g]  <= '0;
        end else if (hit) begin
          case (field_e'(wfield_i))
            FLD_BASE:  base_o[g]  <= wdata_i[PA_W-1:0];
            FLD_LIMIT: limit_o[g] <= wdata_i[BND_W-1:0];
            FLD_CTRL:  ctrl_o[g]  <= seg_ctrl_t'(wdata_i[3:0]);
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (field_e'(rfield_i))
      FLD_BASE:  rdata_o = DATA_W'(base_o[rsel_i]);
      FLD_LIMIT: rdata_o = DATA_W'(limit_o[rsel_i]);
      FLD_CTRL:  rdata_o = DATA_W'(ctrl_o[rsel_i]);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/seg_lane.sv
module seg_lane
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W  = 24,
  parameter int unsigned OFS_W = 14,
  parameter int unsigned BND_W = OFS_W + 1
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [BND_W-1:0] limit_i,
  input  seg_ctrl_t        ctrl_i,
  input  logic [OFS_W-1:0] off_i,
  input  logic [1:0]       acc_i,
  output logic [1:0]       fault_o,
  output logic [PA_W-1:0]  pa_o
);
  localparam logic [BND_W-1:0] SEG_MAX = BND_W'(1) << OFS_W;

  logic [BND_W-1:0] off_ext, mag;
  logic             in_range, allowed;
  logic [PA_W-1:0]  pa_raw;

  assign off_ext = BND_W'(off_i);
  assign mag     = SEG_MAX - off_ext;  // distance below base

  always_comb begin
    if (ctrl_i.down) begin
      in_range = (mag <= limit_i);
      pa_raw   = base_i - PA_W'(mag);
    end else begin
      in_range = (off_ext < limit_i);
      pa_raw   = base_i + PA_W'(off_ext);
    end
  end

  always_comb begin
    case (acc_e'(acc_i))
      ACC_RD:  allowed = ctrl_i.r;
      ACC_WR:  allowed = ctrl_i.w;
      ACC_EX:  allowed = ctrl_i.x;
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (limit_i == '0)  fault_o = FLT_UNUSED;
    else if (!in_range) fault_o = FLT_BOUNDS;
    else if (!allowed)  fault_o = FLT_PROT;
    else                fault_o = FLT_NONE;
    pa_o = (fault_o == FLT_NONE) ? pa_raw : '0;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned PA_W   = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  output logic              resp_valid_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        fault_o,
  input  logic              we_i,
  input  logic [1:0]        wsel_i,
  input  logic [1:0]        wfield_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        rsel_i,
  input  logic [1:0]        rfield_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned OFS_W = VA_W - 2;
  localparam int unsigned BND_W = OFS_W + 1;

  logic [PA_W-1:0]  base  [NUM_SLOTS];
  logic [BND_W-1:0] limit [NUM_SLOTS];
  seg_ctrl_t        ctrl  [NUM_SLOTS];
  logic [1:0]       lane_flt [NUM_SLOTS];
  logic [PA_W-1:0]  lane_pa  [NUM_SLOTS];

  logic [1:0]       sel;
  logic [OFS_W-1:0] off;
  assign sel = va_i[VA_W-1 -: 2];
  assign off = va_i[OFS_W-1:0];

  seg_regfile #(.PA_W(PA_W), .BND_W(BND_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .wsel_i, .wfield_i, .wdata_i,
    .rsel_i, .rfield_i, .rdata_o,
    .base_o(base), .limit_o(limit), .ctrl_o(ctrl)
  );

  // slot 2 has zero limit, so its lane always reports an unused segment
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
    seg_lane #(.PA_W(PA_W), .OFS_W(OFS_W), .BND_W(BND_W)) u_lane (
      .base_i(base[g]), .limit_i(limit[g]), .ctrl_i(ctrl[g]),
      .off_i(off), .acc_i(acc_i),
      .fault_o(lane_flt[g]), .pa_o(lane_pa[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      pa_o         <= '0;
      fault_o      <= FLT_NONE;
    end else begin
      resp_valid_o <= req_valid_i;
      pa_o         <= req_valid_i ? lane_pa[sel]  : '0;
      fault_o      <= req_valid_i ? lane_flt[sel] : FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned PA_W   = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VA_W-1:0]   va_i,
  input logic [1:0]        acc_i,
  input logic              resp_valid_o,
  input logic [PA_W-1:0]   pa_o,
  input logic [1:0]        fault_o,
  input logic [1:0]        rsel_i,
  input logic [DATA_W-1:0] rdata_o
);
  // R8
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && fault_o != 2'b00) |-> (pa_o == '0));

  // R3
  hole_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && va_i[VA_W-1 -: 2] == 2'b10) |=> (fault_o == 2'b11));

  // R9
  resp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && pa_o == '0 && fault_o == 2'b00));

  // R7
  rsv_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && acc_i == 2'b11) |=> (fault_o != 2'b00));

  // R10
  hole_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_i == 2'b10) |-> (rdata_o == '0));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .va_i(va_i),
  .acc_i(acc_i), .resp_valid_o(resp_valid_o), .pa_o(pa_o), .fault_o(fault_o),
  .rsel_i(rsel_i), .rdata_o(rdata_o)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
  localparam int VA_W = 16, PA_W = 24, DATA_W = 32;
  localparam int OFS_W = VA_W - 2, BND_W = OFS_W + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, we_i = 1'b0;
  logic [VA_W-1:0] va_i = '0;
  logic [1:0] acc_i = '0, wsel_i = '0, wfield_i = '0, rsel_i = '0, rfield_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic resp_valid_o;
  logic [PA_W-1:0] pa_o;
  logic [1:0] fault_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic [PA_W-1:0]  m_base [4];
  logic [BND_W-1:0] m_lim  [4];
  logic [3:0]       m_ctl  [4];

  always #2 clk_i = ~clk_i;

  seg_xlate_unit #(.VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W)) dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {fault[1:0], pa}
  function automatic logic [PA_W+1:0] model(logic [VA_W-1:0] va, logic [1:0] acc);
    logic [1:0] s;
    logic [BND_W-1:0] o, mag;
    logic ok, perm;
    s = va[VA_W-1 -: 2];
    o = BND_W'(va[OFS_W-1:0]);
    if (s == 2'b10 || m_lim[s] == '0) return {2'b11, {PA_W{1'b0}}};
    mag = (BND_W'(1) << OFS_W) - o;
    ok = m_ctl[s][3] ? (mag <= m_lim[s]) : (o < m_lim[s]);
    if (!ok) return {2'b01, {PA_W{1'b0}}};
    perm = (acc == 2'b11) ? 1'b0 : m_ctl[s][acc];
    if (!perm) return {2'b10, {PA_W{1'b0}}};
    return {2'b00, m_ctl[s][3] ? m_base[s] - PA_W'(mag) : m_base[s] + PA_W'(o)};
  endfunction

  task automatic wr(logic [1:0] s, logic [1:0] f, logic [DATA_W-1:0] d);
    @(negedge clk_i);
    we_i = 1'b1; wsel_i = s; wfield_i = f; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    if (s != 2'b10) begin
      case (f)
        2'd0: m_base[s] = d[PA_W-1:0];
        2'd1: m_lim[s]  = d[BND_W-1:0];
        2'd2: m_ctl[s]  = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic seg_set(logic [1:0] s, logic [PA_W-1:0] b, logic [BND_W-1:0] l, logic [3:0] c);
    wr(s, 2'd0, DATA_W'(b));
    wr(s, 2'd1, DATA_W'(l));
    wr(s, 2'd2, DATA_W'(c));
  endtask

  task automatic xl(string req, logic [VA_W-1:0] va, logic [1:0] acc);
    logic [PA_W+1:0] e;
    e = model(va, acc);
    @(negedge clk_i);
    req_valid_i = 1'b1; va_i = va; acc_i = acc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({req, " valid"}, 64'(resp_valid_o), 64'd1);
    check({req, " fault"}, 64'(fault_o), 64'(e[PA_W+1:PA_W]));
    check({req, " pa"}, 64'(pa_o), 64'(e[PA_W-1:0]));
  endtask

  task automatic rd(string req, logic [1:0] s, logic [1:0] f, logic [DATA_W-1:0] exp);
    @(negedge clk_i);
    rsel_i = s; rfield_i = f;
    #1 check(req, 64'(rdata_o), 64'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5E6A11));
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_lim[i] = '0; m_ctl[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++) rd("R1 reset readback", 2'(s), 2'(f), '0);
    xl("R1 reset access", 16'h0010, 2'b00);
    xl("R1 reset stack", 16'hC000, 2'b01);

    // R9 idle outputs
    @(negedge clk_i);
    check("R9 idle valid", 64'(resp_valid_o), 64'd0);
    check("R9 idle pa", 64'(pa_o), 64'd0);

    // R10 register port
    seg_set(2'b00, 24'h10_0000, 15'd256, 4'b0101);
    seg_set(2'b01, 24'h20_0000, 15'd1024, 4'b0011);
    seg_set(2'b11, 24'h30_0000, 15'd512, 4'b1011);
    rd("R10 base read", 2'b00, 2'd0, 32'h10_0000);
    rd("R10 limit read", 2'b01, 2'd1, 32'd1024);
    rd("R10 ctrl read", 2'b11, 2'd2, 32'hB);
    wr(2'b10, 2'd1, 32'd99);
    rd("R10 slot2 ignored", 2'b10, 2'd1, '0);
    wr(2'b00, 2'd3, 32'hFFFF);
    rd("R10 field3 ignored", 2'b00, 2'd3, '0);
    rd("R10 field3 no side effect", 2'b00, 2'd2, 32'h5);
    wr(2'b00, 2'd0, 32'hFF10_0000);
    rd("R10 base truncation", 2'b00, 2'd0, 32'h10_0000);

    // R2 R5 upward, boundaries
    xl("R2 R5 code low", 16'h0000, 2'b00);
    xl("R5 code last", 16'h00FF, 2'b10);
    xl("R5 code over", 16'h0100, 2'b00);
    xl("R2 R5 heap", 16'h4123, 2'b01);
    xl("R5 heap over", 16'h4400, 2'b01);
    // R3 select 10
    xl("R3 hole", 16'h8000, 2'b00);
    // R6 downward boundaries
    xl("R6 stack edge", 16'hFE00, 2'b00);
    xl("R6 stack below edge", 16'hFDFF, 2'b00);
    xl("R6 stack top", 16'hFFFF, 2'b01);
    xl("R6 stack off zero", 16'hC000, 2'b00);
    // R7 permissions and priority
    xl("R7 code write denied", 16'h0004, 2'b01);
    xl("R7 heap exec denied", 16'h4004, 2'b10);
    xl("R7 reserved access", 16'h4004, 2'b11);
    xl("R7 bounds before prot", 16'h0200, 2'b01);
    // R4 zero limit
    wr(2'b01, 2'd1, 32'd0);
    xl("R4 heap unused", 16'h4000, 2'b00);
    // R6 full size stack, wrap of base
    seg_set(2'b11, 24'h00_0010, 15'h4000, 4'b1111);
    xl("R6 full size zero offset", 16'hC000, 2'b00);
    seg_set(2'b00, 24'hFF_FFF0, 15'h4000, 4'b0111);
    xl("R5 base wrap", 16'h0020, 2'b00);

    // random phase (R2 R4 R5 R6 R7 R8)
    for (int it = 0; it < 600; it++) begin
      logic [1:0] s;
      logic [BND_W-1:0] l;
      logic [OFS_W-1:0] o;
      logic [VA_W-1:0] va;
      if (it % 25 == 0) begin
        s = 2'($urandom_range(0, 3));
        case ($urandom_range(0, 4))
          0: l = '0;
          1: l = 15'h4000;
          default: l = 15'($urandom_range(1, 16384));
        endcase
        seg_set(s, 24'($urandom), l, 4'($urandom));
      end
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin
        if (m_ctl[s][3]) o = OFS_W'(15'h4000 - m_lim[s] + 15'($urandom_range(0, 4)) - 15'd2);
        else             o = OFS_W'(m_lim[s] + 15'($urandom_range(0, 4)) - 15'd2);
      end else o = OFS_W'($urandom);
      va = {s, o};
      xl("R2 R4 R5 R6 R7 R8 random", va, 2'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule